// File: doc/BRIEF.md
# Interconnect Error Capture Unit

This block collects error events from an on-chip interconnect and presents them to software through a small 32-bit register port. The interconnect raises single-cycle pulses, one line per error kind: local access window miss, coherency violation, unavailable target, and multicast stash. Each pulse comes with the source ID and the 40-bit address of the offending transaction. Each kind sets a sticky flag unless software has switched off its detection. The first error that arrives while the unit is armed also freezes its source ID, its address, its kind and the set of kinds seen in that cycle. This record is kept until software re-arms the unit.

A level interrupt is raised, one cycle after the flag state, whenever a flag is set whose interrupt-enable bit is also set. Software reads the flag register. It then writes the same value back, which clears the flags it saw and the capture-valid bit, and this re-arms capture. Register reads are registered: the data appears one cycle after the offset is presented.

Top module: `icx_errcap`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: A pulse on `err_evt[i]` (i = 0 local access, 1 coherency, 2 unavailable target, 3 multicast stash) sets bit i of the flag register at byte offset 0x00. The bit stays set until it is cleared by a write.
- R3: Bit i of the detection-disable register (offset 0x04, bits 3:0, read/write) stops `err_evt[i]` from setting a flag or starting a capture. A value of zero leaves all detection on.
- R4: A write to offset 0x00 clears each flag bit written as 1 and leaves flag bits written as 0 unchanged. An enabled event that arrives in the same cycle as a clear of its bit leaves that bit set.
- R5: An enabled event that finds the unit armed latches its capture record. Flag bit 31 (capture-valid) becomes 1. Bits 30:26 hold the index of the lowest-numbered enabled event in that cycle. The source ID goes to offset 0x0C bits 25:18. Address bits 39:32 go to offset 0x10 bits 7:0, and address bits 31:0 go to offset 0x14. The type field reads 0 while capture-valid is 0.
- R6: While capture-valid is 1, later events set their flags but do not change the captured source, address, type or mask. Writing 1 to bit 31 at offset 0x00 re-arms capture. If an enabled event arrives in the same cycle as that write, it is captured and capture-valid stays 1.
- R7: `irq` equals, one cycle later, the OR over bits 3:0 of (flags AND interrupt-enable), where the interrupt-enable register sits at offset 0x08, bits 3:0, read/write.
- R8: `reg_rdata` shows, one cycle after `reg_addr` is presented, the register at word offset `reg_addr[4:2]`. Offset 0x1C reads zero, and unused bits of every register read zero.
- R9: Writes to offsets 0x0C, 0x10, 0x14, 0x18 and 0x1C have no effect.
- R10: Offset 0x18 bits 3:0 hold the mask of enabled events present in the cycle the capture was taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_evt | input | N_ERR | Single-cycle error pulses, one per kind |
| err_src | input | SRC_W | Source ID accompanying the pulses |
| err_addr | input | ADDR_W | Transaction address accompanying the pulses |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | OFF_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt |

## Verification
Two things can land in the same cycle: the software write-back to the flag register and a fresh error pulse. This can happen to the same flag bit and to capture-valid. The bench drives the pair on one clock edge, once on purpose and many more times through random stimulus. The flag must survive, and the new source and address must be captured in place of the old record. A behavioural model checks every read value and the interrupt on every clock. Ties between kinds in one cycle, with and without a disable mask, are judged in the same way through the captured type and mask.

// File: rtl/icx_errcap_pkg.sv
package icx_errcap_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned CV_BIT   = 31;
  localparam int unsigned TYPE_LSB = 26;
  localparam int unsigned TYPE_W   = 5;
  localparam int unsigned SRC_LSB  = 18;
  localparam int unsigned LOW_W    = 32;

  typedef enum logic [2:0] {
    IDX_FLAGS = 3'd0,
    IDX_DIS   = 3'd1,
    IDX_IEN   = 3'd2,
    IDX_ATTR  = 3'd3,
    IDX_AHI   = 3'd4,
    IDX_ALO   = 3'd5,
    IDX_MASK  = 3'd6,
    IDX_HOLE  = 3'd7
  } reg_idx_e;
endpackage

// File: rtl/icx_errcap_flags.sv
module icx_errcap_flags #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] dis,
  input  logic [N-1:0] clr,
  output logic [N-1:0] evt_en,
  output logic [N-1:0] det_q
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    assign evt_en[g] = evt[g] & ~dis[g];
    // set has priority over clear
    always_ff @(posedge clk) begin
      if (rst) det_q[g] <= 1'b0;
      else     det_q[g] <= (det_q[g] & ~clr[g]) | evt_en[g];
    end
  end
endmodule

// File: rtl/icx_errcap_snap.sv
module icx_errcap_snap #(
  parameter int unsigned N      = 4,
  parameter int unsigned SRC_W  = 8,
  parameter int unsigned ADDR_W = 40,
  parameter int unsigned TYPE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      evt_en,
  input  logic [SRC_W-1:0]  src,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rearm,
  output logic              cap_valid,
  output logic [TYPE_W-1:0] cap_type,
  output logic [SRC_W-1:0]  cap_src,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [N-1:0]      cap_mask
);
  logic [TYPE_W-1:0] low_idx;
  logic              armed;
  logic              take;

  // lowest-numbered event wins the type field
  always_comb begin
    low_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (evt_en[i]) low_idx = TYPE_W'(i);
    end
  end

  assign armed = ~cap_valid | rearm;
  assign take  = armed & (|evt_en);

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_valid <= 1'b0;
    end else if (take) begin
      cap_valid <= 1'b1;
    end else if (rearm) begin
      cap_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_type <= '0;
      cap_src  <= '0;
      cap_addr <= '0;
      cap_mask <= '0;
    end else if (take) begin
      cap_type <= low_idx;
      cap_src  <= src;
      cap_addr <= addr;
      cap_mask <= evt_en;
    end
  end
endmodule

// File: rtl/icx_errcap_regs.sv
module icx_errcap_regs
  import icx_errcap_pkg::*;
#(
  parameter int unsigned N      = 4,
  parameter int unsigned SRC_W  = 8,
  parameter int unsigned ADDR_W = 40,
  parameter int unsigned OFF_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic [N-1:0]      det_q,
  input  logic              cap_valid,
  input  logic [TYPE_W-1:0] cap_type,
  input  logic [SRC_W-1:0]  cap_src,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [N-1:0]      cap_mask,
  output logic [N-1:0]      dis_q,
  output logic [N-1:0]      ien_q,
  output logic [N-1:0]      clr_det,
  output logic              rearm,
  output logic [REG_W-1:0]  rdata_q,
  output logic              irq_q
);
  localparam int unsigned IDX_W = OFF_W - 2;
  localparam int unsigned AHI_W = ADDR_W - LOW_W;

  reg_idx_e   idx;
  logic       wr_flags;
  logic       wr_dis;
  logic       wr_ien;
  logic [REG_W-1:0] rd_word;
  logic       unused_bits;

  assign idx      = reg_idx_e'(addr[OFF_W-1:2]);
  assign wr_flags = wr_en & (idx == IDX_FLAGS);
  assign wr_dis   = wr_en & (idx == IDX_DIS);
  assign wr_ien   = wr_en & (idx == IDX_IEN);

  assign clr_det  = wr_flags ? wdata[N-1:0] : '0;
  assign rearm    = wr_flags & wdata[CV_BIT];

  assign unused_bits = ^{wdata[REG_W-2:N], addr[1:0], IDX_W[0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      dis_q <= '0;
      ien_q <= '0;
    end else begin
      if (wr_dis) dis_q <= wdata[N-1:0];
      if (wr_ien) ien_q <= wdata[N-1:0];
    end
  end

  always_comb begin
    rd_word = '0;
    unique case (idx)
      IDX_FLAGS: begin
        rd_word[N-1:0]  = det_q;
        rd_word[CV_BIT] = cap_valid;
        if (cap_valid) rd_word[TYPE_LSB +: TYPE_W] = cap_type;
      end
      IDX_DIS:  rd_word[N-1:0] = dis_q;
      IDX_IEN:  rd_word[N-1:0] = ien_q;
      IDX_ATTR: rd_word[SRC_LSB +: SRC_W] = cap_src;
      IDX_AHI:  rd_word[AHI_W-1:0] = cap_addr[ADDR_W-1:LOW_W];
      IDX_ALO:  rd_word[LOW_W-1:0] = cap_addr[LOW_W-1:0];
      IDX_MASK: rd_word[N-1:0] = cap_mask;
      default:  rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      rdata_q <= rd_word;
      irq_q   <= |(det_q & ien_q);
    end
  end
endmodule

// File: rtl/icx_errcap.sv
module icx_errcap
  import icx_errcap_pkg::*;
#(
  parameter int unsigned N_ERR  = 4,
  parameter int unsigned SRC_W  = 8,
  parameter int unsigned ADDR_W = 40,
  parameter int unsigned OFF_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_ERR-1:0]  err_evt,
  input  logic [SRC_W-1:0]  err_src,
  input  logic [ADDR_W-1:0] err_addr,
  input  logic              reg_wr_en,
  input  logic [OFF_W-1:0]  reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq
);
  logic [N_ERR-1:0]  evt_en;
  logic [N_ERR-1:0]  det_q;
  logic [N_ERR-1:0]  dis_q;
  logic [N_ERR-1:0]  ien_q;
  logic [N_ERR-1:0]  clr_det;
  logic              rearm;
  logic              cap_valid;
  logic [TYPE_W-1:0] cap_type;
  logic [SRC_W-1:0]  cap_src;
  logic [ADDR_W-1:0] cap_addr;
  logic [N_ERR-1:0]  cap_mask;

  icx_errcap_flags #(.N(N_ERR)) u_flags (
    .clk    (clk),
    .rst    (rst),
    .evt    (err_evt),
    .dis    (dis_q),
    .clr    (clr_det),
    .evt_en (evt_en),
    .det_q  (det_q)
  );

  icx_errcap_snap #(
    .N(N_ERR), .SRC_W(SRC_W), .ADDR_W(ADDR_W), .TYPE_W(TYPE_W)
  ) u_snap (
    .clk       (clk),
    .rst       (rst),
    .evt_en    (evt_en),
    .src       (err_src),
    .addr      (err_addr),
    .rearm     (rearm),
    .cap_valid (cap_valid),
    .cap_type  (cap_type),
    .cap_src   (cap_src),
    .cap_addr  (cap_addr),
    .cap_mask  (cap_mask)
  );

  icx_errcap_regs #(
    .N(N_ERR), .SRC_W(SRC_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (reg_wr_en),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .det_q     (det_q),
    .cap_valid (cap_valid),
    .cap_type  (cap_type),
    .cap_src   (cap_src),
    .cap_addr  (cap_addr),
    .cap_mask  (cap_mask),
    .dis_q     (dis_q),
    .ien_q     (ien_q),
    .clr_det   (clr_det),
    .rearm     (rearm),
    .rdata_q   (reg_rdata),
    .irq_q     (irq)
  );
endmodule

// File: rtl/icx_errcap_chk.sv
module icx_errcap_chk #(
  parameter int unsigned N      = 4,
  parameter int unsigned SRC_W  = 8,
  parameter int unsigned ADDR_W = 40,
  parameter int unsigned OFF_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [N-1:0]      err_evt,
  input logic [SRC_W-1:0]  err_src,
  input logic [ADDR_W-1:0] err_addr,
  input logic              reg_wr_en,
  input logic [OFF_W-1:0]  reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic              irq,
  input logic [N-1:0]      det_q,
  input logic [N-1:0]      dis_q,
  input logic [N-1:0]      ien_q,
  input logic              cap_valid,
  input logic [SRC_W-1:0]  cap_src,
  input logic [ADDR_W-1:0] cap_addr
);
  logic         wr_flags;
  logic [N-1:0] live;
  assign wr_flags = reg_wr_en && (reg_addr[OFF_W-1:2] == '0);
  assign live     = err_evt & ~dis_q;

  // R2
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (det_q != '0) && !wr_flags |=> ((det_q & $past(det_q)) == $past(det_q)));

  // R3
  dis_gate_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((det_q & ~$past(det_q) & $past(dis_q)) == '0));

  // R4
  set_beats_clr_chk: assert property (@(posedge clk) disable iff (rst)
    wr_flags && (live != '0) |=> ((det_q & $past(live)) == $past(live)));

  // R5
  cap_take_chk: assert property (@(posedge clk) disable iff (rst)
    !cap_valid && (live != '0) |=>
      cap_valid && cap_src == $past(err_src) && cap_addr == $past(err_addr));

  // R6
  cap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cap_valid && !(wr_flags && reg_wdata[31]) |=>
      cap_valid && $stable(cap_src) && $stable(cap_addr));

  // R7
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == (|$past(det_q & ien_q))));

  // R8
  hole_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_addr[OFF_W-1:2] == '1) |=> (reg_rdata == '0));
endmodule

bind icx_errcap icx_errcap_chk #(
  .N(N_ERR), .SRC_W(SRC_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .err_evt   (err_evt),
  .err_src   (err_src),
  .err_addr  (err_addr),
  .reg_wr_en (reg_wr_en),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .irq       (irq),
  .det_q     (det_q),
  .dis_q     (dis_q),
  .ien_q     (ien_q),
  .cap_valid (cap_valid),
  .cap_src   (cap_src),
  .cap_addr  (cap_addr)
);

// File: tb/test_icx_errcap.sv
`timescale 1ns/1ps
module test_icx_errcap;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  err_evt = '0;
  logic [7:0]  err_src = '0;
  logic [39:0] err_addr = '0;
  logic        reg_wr_en = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  icx_errcap i_icx_errcap (
    .clk(clk), .rst(rst), .err_evt(err_evt), .err_src(err_src),
    .err_addr(err_addr), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // behavioural reference
  logic [3:0]  m_det, m_dis, m_ien, m_mask;
  logic        m_cv, m_irq;
  int          m_type;
  logic [7:0]  m_src;
  logic [39:0] m_addr;
  logic [31:0] m_rdata;
  int          m_ridx;

  function automatic logic [31:0] model_read(int idx);
    logic [31:0] w = 32'h0;
    case (idx)
      0: begin
        w = {28'h0, m_det};
        if (m_cv) w = w | 32'h8000_0000 | (32'(m_type) << 26);
      end
      1: w = {28'h0, m_dis};
      2: w = {28'h0, m_ien};
      3: w = 32'(m_src) << 18;
      4: w = {24'h0, m_addr[39:32]};
      5: w = m_addr[31:0];
      6: w = {28'h0, m_mask};
      default: w = 32'h0;
    endcase
    return w;
  endfunction

  function automatic string tag_of(int idx);
    case (idx)
      0: return "R4";
      1: return "R3";
      2: return "R7";
      3: return "R5";
      4: return "R5";
      5: return "R5";
      6: return "R10";
      default: return "R8";
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_det = 0; m_dis = 0; m_ien = 0; m_mask = 0; m_cv = 0; m_irq = 0;
      m_type = 0; m_src = 0; m_addr = 0; m_rdata = 0; m_ridx = 0;
    end else begin
      logic [3:0]  en;
      logic [31:0] clr;
      int          idx;
      idx = int'(reg_addr[4:2]);
      m_rdata = model_read(idx);
      m_ridx  = idx;
      m_irq   = |(m_det & m_ien);
      en  = err_evt & ~m_dis;
      clr = (reg_wr_en && idx == 0) ? reg_wdata : 32'h0;
      if ((!m_cv || clr[31]) && en != 0) begin
        m_cv = 1'b1;
        for (int i = 3; i >= 0; i--) if (en[i]) m_type = i;
        m_src = err_src; m_addr = err_addr; m_mask = en;
      end else if (clr[31]) begin
        m_cv = 1'b0;
      end
      m_det = (m_det & ~clr[3:0]) | en;
      if (reg_wr_en && idx == 1) m_dis = reg_wdata[3:0];
      if (reg_wr_en && idx == 2) m_ien = reg_wdata[3:0];
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // compare against the model on every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R7", {31'h0, irq}, {31'h0, m_irq});
      chk(tag_of(m_ridx), reg_rdata, m_rdata);
    end
  end

  task automatic drive(logic wr, logic [4:0] a, logic [31:0] wd,
                       logic [3:0] e, logic [7:0] s, logic [39:0] ea);
    @(negedge clk);
    #1;
    reg_wr_en = wr; reg_addr = a; reg_wdata = wd;
    err_evt = e; err_src = s; err_addr = ea;
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] wd);
    drive(1'b1, a, wd, 4'h0, 8'h0, 40'h0);
  endtask

  task automatic evt(logic [3:0] e, logic [7:0] s, logic [39:0] ea);
    drive(1'b0, 5'h0, 32'h0, e, s, ea);
  endtask

  task automatic rd(logic [4:0] a, logic [31:0] exp, string tag);
    drive(1'b0, a, 32'h0, 4'h0, 8'h0, 40'h0);
    @(negedge clk);
    chk(tag, reg_rdata, exp);
  endtask

  task automatic summary();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    for (int a = 0; a < 8; a++) rd(5'(a * 4), 32'h0, "R1");
    chk("R1", {31'h0, irq}, 32'h0);

    // R2, R5, R10: single coherency event
    evt(4'h2, 8'h5A, 40'h12_3456_789A);
    rd(5'h00, 32'h8400_0002, "R2");
    rd(5'h0C, 32'h0168_0000, "R5");
    rd(5'h10, 32'h0000_0012, "R5");
    rd(5'h14, 32'h3456_789A, "R5");
    rd(5'h18, 32'h0000_0002, "R10");

    // R6: later event flags only
    evt(4'h8, 8'hC3, 40'hFF_0000_0000);
    rd(5'h00, 32'h8400_000A, "R6");
    rd(5'h0C, 32'h0168_0000, "R6");

    // R7: interrupt enable for bit 3
    wr(5'h08, 32'hFFFF_FFF8);
    rd(5'h08, 32'h0000_0008, "R8");
    chk("R7", {31'h0, irq}, 32'h1);

    // R4: write-back clears flags and capture-valid
    wr(5'h00, 32'h8400_000A);
    rd(5'h00, 32'h0, "R4");
    chk("R7", {31'h0, irq}, 32'h0);

    // R3, R5, R10: disable bit 0, tie of bits 0 and 2
    wr(5'h04, 32'h0000_0001);
    evt(4'h5, 8'h77, 40'h01_0000_0010);
    rd(5'h00, 32'h8800_0004, "R3");
    rd(5'h18, 32'h0000_0004, "R10");

    // R4, R6: clear and new event in the same cycle
    drive(1'b1, 5'h00, 32'h8000_0004, 4'h4, 8'h33, 40'hAB_0000_0001);
    rd(5'h00, 32'h8800_0004, "R4");
    rd(5'h0C, 32'h00CC_0000, "R6");
    rd(5'h10, 32'h0000_00AB, "R6");
    rd(5'h14, 32'h0000_0001, "R6");

    // R9: read-only and hole offsets ignore writes
    for (int a = 3; a < 8; a++) wr(5'(a * 4), 32'hFFFF_FFFF);
    rd(5'h0C, 32'h00CC_0000, "R9");
    rd(5'h14, 32'h0000_0001, "R9");
    rd(5'h18, 32'h0000_0004, "R9");
    rd(5'h1C, 32'h0, "R8");
    rd(5'h04, 32'h0000_0001, "R3");

    // mixed traffic, judged by the model each cycle
    wr(5'h04, 32'h0);
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r = $urandom;
      logic        w = (r[1:0] == 2'b00);
      logic [3:0]  e = (r[3:2] == 2'b00) ? 4'($urandom) : 4'h0;
      logic [31:0] wd = $urandom;
      drive(w, 5'($urandom), wd, e, 8'($urandom), {8'($urandom), 32'($urandom)});
    end
    evt(4'h0, 8'h0, 40'h0);
    @(negedge clk);
    @(negedge clk);
    summary();
    $finish;
  end
endmodule